// File: doc/BRIEF.md
# Five-Cycle Multicycle 32-bit Processor Core

This block is a small non-pipelined 32-bit processor. Each instruction moves through five fixed phases: instruction fetch, operand read, ALU, memory access and register update. Each phase takes one clock, so every instruction, a halt included, costs exactly five cycles. The core has eight general registers and a set of internal staging registers: operand A, operand B, ALU result, memory-stage result, store data, instruction and program counter. It has no branches. A program runs straight from word address 0 until it reaches a halt.

The core shares one word-addressed memory for code and data. It drives an 8-bit address, a read strobe and a write strobe, and it expects read data to come back combinationally in the same cycle. Immediates are always zero-extended. Register R0 is an ordinary register, but the asynchronous reset clears it along with the rest of the register file, so a freshly reset program can use R0 as a zero base.

Top module: `mc_core`

## Requirements
- R1: Instruction bits [31:28] hold the opcode, [27:25] the destination register, [24:22] source A and [21:19] source B. The register forms ADD (0100), SUB (0110), AND (1000) and OR (1010) write the result of A op B to the destination. Subtraction is A minus B modulo 2^32.
- R2: The immediate forms ADI (0101), SUI (0111), ANI (1001) and ORI (1011) use bits [15:0] zero-extended to 32 bits in place of source B. The source B field is ignored.
- R3: Opcode 0000 copies source A to the destination. Opcode 0001 writes the zero-extended immediate to the destination.
- R4: LOAD (0010) writes to the destination the memory word at address (source A + zero-extended immediate). Only the low 8 bits of that sum drive `mem_addr`.
- R5: STORE (0011) writes the register named by the source B field to address (source A + immediate), truncated to 8 bits. The destination field is ignored. Each store raises `mem_wr` for exactly one cycle. `mem_rd` and `mem_wr` are never high together.
- R6: Execution starts at address 0. The program counter advances by one at each fetch. Every instruction takes exactly five clock cycles, so a program of N instructions that ends in a halt raises `halted` exactly 5N cycles after reset is released.
- R7: After HLT (1100) completes, `halted` stays high and the core raises neither memory strobe again until reset.
- R8: Opcodes 1101, 1110 and 1111 are no-operations. They take five cycles and change no register and no memory word.
- R9: An active-low asynchronous reset clears the register file, the program counter and `halted` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Word address: the PC during fetch, the ALU result during the memory phase |
| mem_rdata | input | 32 | Read data, valid in the same cycle as the address |
| mem_wdata | output | 32 | Store data |
| mem_rd | output | 1 | Read strobe (fetch or load) |
| mem_wr | output | 1 | Write strobe (store) |
| halted | output | 1 | High once a halt instruction has completed |

## Verification
The embedded assertions check the sequencing on every cycle. They confirm that the PC steps by one per fetch, that the phase returns to fetch after every register-update phase, that the two strobes are exclusive, that a write strobe never lasts two cycles, and that a halted core stays halted and silent. Only the bench scenarios can show that the data is right. They sweep every ALU opcode over a grid of 32-bit operands and immediates, and exercise address wrap-around through the 8-bit truncation, the ignored destination field of a store, the no-operation opcodes, and the clearing of registers by an asynchronous reset. Each of these results is visible only in the memory words a program leaves behind.

// File: rtl/mc_core.sv
module mc_core #(
  parameter int DW  = 32,
  parameter int AW  = 8,
  parameter int PCW = 16,
  parameter int RN  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          halted
);
  localparam int RW = $clog2(RN);

  typedef enum logic [2:0] {PH_IF, PH_ID, PH_EX, PH_MEM, PH_WB} phase_t;

  phase_t         phase;
  logic [PCW-1:0] pc;
  logic [DW-1:0]  ir, ra, rb, rz, ry, rm, alu;
  logic [DW-1:0]  rf [RN];

  wire [3:0]    op    = ir[31:28];
  wire [RW-1:0] f_dst = ir[25+:RW];
  wire [RW-1:0] f_sa  = ir[22+:RW];
  wire [RW-1:0] f_sb  = ir[19+:RW];
  wire [DW-1:0] imm_z = {{(DW-16){1'b0}}, ir[15:0]};

  wire is_ld   = op == 4'd2;
  wire is_st   = op == 4'd3;
  wire is_hlt  = op == 4'd12;
  wire use_imm = op == 4'd1 || is_ld || is_st ||
                 (op >= 4'd5 && op <= 4'd11 && op[0]);
  wire wr_reg  = op <= 4'd2 || (op >= 4'd4 && op <= 4'd11);

  always_comb begin
    case (op)
      4'd0:                   alu = ra;
      4'd1:                   alu = rb;
      4'd2, 4'd3, 4'd4, 4'd5: alu = ra + rb;
      4'd6, 4'd7:             alu = ra - rb;
      4'd8, 4'd9:             alu = ra & rb;
      4'd10, 4'd11:           alu = ra | rb;
      default:                alu = '0;
    endcase
  end

  assign mem_addr  = (phase == PH_MEM) ? rz[AW-1:0] : pc[AW-1:0];
  assign mem_rd    = !halted && (phase == PH_IF || (phase == PH_MEM && is_ld));
  assign mem_wr    = !halted && phase == PH_MEM && is_st;
  assign mem_wdata = rm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RN; i++) rf[i] <= '0;
    end else if (!halted && phase == PH_WB && wr_reg) begin
      rf[f_dst] <= ry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IF;
      pc     <= '0;
      halted <= 1'b0;
      ir <= '0; ra <= '0; rb <= '0; rz <= '0; ry <= '0; rm <= '0;
    end else if (!halted) begin
      case (phase)
        PH_IF: begin
          ir    <= mem_rdata;
          pc    <= pc + PCW'(1);
          phase <= PH_ID;
        end
        PH_ID: begin
          ra    <= rf[f_sa];
          rb    <= use_imm ? imm_z : rf[f_sb];
          rm    <= rf[f_sb];
          phase <= PH_EX;
        end
        PH_EX: begin
          rz    <= alu;
          phase <= PH_MEM;
        end
        PH_MEM: begin
          ry    <= is_ld ? mem_rdata : rz;
          phase <= PH_WB;
        end
        default: begin
          if (is_hlt) halted <= 1'b1;
          phase <= PH_IF;
        end
      endcase
    end
  end

  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IF && !halted) |=> pc == $past(pc) + PCW'(1));

  // R6
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WB) |=> (phase == PH_IF));

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_rd && !mem_wr));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R5
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
endmodule

// File: tb/mc_core_test.sv
module mc_core_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [31:0] mem_rdata, mem_wdata;
  logic        mem_rd, mem_wr, halted;

  logic [31:0] mem [256];
  logic [31:0] img [256];
  int          wr_cnt, rd_cnt, cyc_total;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mc_core uut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= img[i];
      wr_cnt <= 0;
      rd_cnt <= 0;
    end else begin
      if (mem_wr) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (mem_rd) rd_cnt <= rd_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total >= 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc_total);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] enc(input int op, input int d, input int a,
                                      input int b, input int imm);
    return {op[3:0], d[2:0], a[2:0], b[2:0], 3'b000, imm[15:0]};
  endfunction

  function automatic logic [31:0] model(input int op, input logic [31:0] a,
                                        input logic [31:0] b);
    case (op)
      4, 5:    return a + b;
      6, 7:    return a - b;
      8, 9:    return a & b;
      default: return a | b;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clr_img();
    for (int i = 0; i < 256; i++) img[i] = '0;
  endtask

  task automatic run(output int cyc);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
    end
  endtask

  logic [31:0] vals [6];
  int          imms [5];

  initial begin
    int cyc;
    cyc_total = 0;
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'h1234_5678; vals[5] = 32'h0F0F_F0F0;
    imms[0] = 0; imms[1] = 1; imms[2] = 'h8000; imms[3] = 'hFFFF; imms[4] = 'h1234;
    clr_img();
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check(halted == 1'b0, "R9 halted in reset", 32'(halted), 0);
    check(mem_addr == 8'd0 && !mem_wr, "R6 addr in reset", 32'(mem_addr), 0);

    // R1 register ALU sweep
    for (int op = 4; op <= 10; op += 2)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++) begin
          clr_img();
          img[0] = enc(2, 1, 0, 0, 200);
          img[1] = enc(2, 2, 0, 0, 201);
          img[2] = enc(op, 3, 1, 2, 'hABCD);
          img[3] = enc(3, 0, 0, 3, 202);
          img[4] = enc(12, 0, 0, 0, 0);
          img[200] = vals[i];
          img[201] = vals[j];
          run(cyc);
          check(mem[202] == model(op, vals[i], vals[j]), "R1 reg alu",
                mem[202], model(op, vals[i], vals[j]));
          if (i == 0 && j == 0)
            check(cyc == 25, "R6 cycle count", 32'(cyc), 25);
        end

    // R2 immediate ALU sweep
    for (int op = 5; op <= 11; op += 2)
      for (int i = 0; i < 6; i++)
        for (int k = 0; k < 5; k++) begin
          clr_img();
          img[0] = enc(2, 1, 0, 0, 200);
          img[1] = enc(op, 3, 1, 1, imms[k]);
          img[2] = enc(3, 0, 0, 3, 202);
          img[3] = enc(12, 0, 0, 0, 0);
          img[200] = vals[i];
          run(cyc);
          check(mem[202] == model(op, vals[i], 32'(imms[k])), "R2 imm alu",
                mem[202], model(op, vals[i], 32'(imms[k])));
        end

    // R3 moves
    for (int k = 0; k < 5; k++) begin
      clr_img();
      img[0] = enc(2, 1, 0, 0, 200);
      img[1] = enc(0, 5, 1, 7, 'h5555);
      img[2] = enc(1, 6, 3, 4, imms[k]);
      img[3] = enc(3, 0, 0, 5, 202);
      img[4] = enc(3, 0, 0, 6, 203);
      img[5] = enc(12, 0, 0, 0, 0);
      img[200] = vals[k];
      run(cyc);
      check(mem[202] == vals[k], "R3 move reg", mem[202], vals[k]);
      check(mem[203] == 32'(imms[k]), "R3 move imm", mem[203], 32'(imms[k]));
      check(wr_cnt == 2, "R5 write count", 32'(wr_cnt), 2);
      check(cyc == 30, "R6 cycle count", 32'(cyc), 30);
    end

    // R4 load/store address truncation and base register
    clr_img();
    img[0] = enc(2, 1, 0, 0, 'h1C8);
    img[1] = enc(5, 2, 0, 0, 'h100);
    img[2] = enc(2, 3, 2, 0, 'h0C9);
    img[3] = enc(3, 0, 2, 1, 'h0CA);
    img[4] = enc(3, 0, 0, 3, 'h3CB);
    img[5] = enc(12, 0, 0, 0, 0);
    img[200] = 32'hCAFE_0001;
    img[201] = 32'hCAFE_0002;
    run(cyc);
    check(mem[202] == 32'hCAFE_0001, "R4 load truncated", mem[202], 32'hCAFE_0001);
    check(mem[203] == 32'hCAFE_0002, "R4 load via base", mem[203], 32'hCAFE_0002);

    // R5 store ignores destination field
    clr_img();
    img[0] = enc(2, 1, 0, 0, 200);
    img[1] = enc(2, 2, 0, 0, 201);
    img[2] = enc(3, 2, 0, 1, 202);
    img[3] = enc(3, 0, 0, 2, 203);
    img[4] = enc(12, 0, 0, 0, 0);
    img[200] = 32'h1111_2222;
    img[201] = 32'h3333_4444;
    run(cyc);
    check(mem[202] == 32'h1111_2222, "R5 store data", mem[202], 32'h1111_2222);
    check(mem[203] == 32'h3333_4444, "R5 dest ignored", mem[203], 32'h3333_4444);
    check(wr_cnt == 2, "R5 write count", 32'(wr_cnt), 2);

    // R7 halt: no fetches afterwards
    begin
      int rd_before;
      rd_before = rd_cnt;
      repeat (20) @(posedge clk);
      @(negedge clk);
      check(rd_cnt == rd_before && wr_cnt == 2, "R7 silent after halt",
            32'(rd_cnt), 32'(rd_before));
      check(halted == 1'b1, "R7 halted sticky", 32'(halted), 1);
    end

    // R8 no-op opcodes
    clr_img();
    img[0] = enc(2, 1, 0, 0, 200);
    img[1] = enc(13, 1, 0, 0, 5);
    img[2] = enc(14, 1, 1, 1, 'hFFFF);
    img[3] = enc(15, 1, 2, 3, 'h00CA);
    img[4] = enc(3, 0, 0, 1, 202);
    img[5] = enc(12, 0, 0, 0, 0);
    img[200] = 32'h7777_8888;
    img[202] = 32'h5A5A_5A5A;
    run(cyc);
    check(mem[202] == 32'h7777_8888, "R8 noop keeps reg", mem[202], 32'h7777_8888);
    check(wr_cnt == 1, "R8 noop no write", 32'(wr_cnt), 1);
    check(cyc == 30, "R8 noop cycles", 32'(cyc), 30);

    // R9 asynchronous reset clears registers and halted
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check(halted == 1'b0, "R9 async halted clear", 32'(halted), 0);
    check(mem_addr == 8'd0, "R9 async pc clear", 32'(mem_addr), 0);
    clr_img();
    img[0] = enc(3, 0, 0, 1, 202);
    img[1] = enc(12, 0, 0, 0, 0);
    img[202] = 32'hDEAD_BEEF;
    run(cyc);
    check(mem[202] == 32'h0, "R9 regs cleared", mem[202], 0);

    // R9 mid-run reset returns to address 0
    clr_img();
    img[0] = enc(2, 1, 0, 0, 200);
    img[1] = enc(2, 2, 0, 0, 200);
    img[2] = enc(12, 0, 0, 0, 0);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (7) @(posedge clk);
    #2 rst_n = 1'b0;
    #1;
    check(mem_addr == 8'd0 && mem_rd, "R9 mid-run reset", 32'(mem_addr), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule